// File: doc/BRIEF.md
# Nibble-Carry Video Matrix Counter

This block keeps the running screen offset for a character-based video generator. A 12-bit counter advances by one after every character fetch along a raster line. At the start of each line it is reloaded from a base register. On the last raster line of a character row, the base register takes the counter's end-of-line value, so the next row continues where the previous one stopped. The memory address of each fetch is the counter plus one, halved.

The counter is built from three 4-bit nibbles. The carry into the lowest nibble is immediate. The carries into the middle and top nibbles are kept in hold registers. These registers change only on a step. A load therefore adds whatever carries the last step of the previous line left behind, one into each upper nibble, and each added carry wraps inside its own nibble. A line that ends with the low byte at zero makes the next reload come out $110 higher than the base. A line that ends with only the low nibble at zero makes it come out $010 higher.

All strobes are sampled on one clock and qualified by a phase enable. Load and step are never asserted together.

Top module: `vmc_top`

## Requirements
- R1: While `rst_n` is low, the counter, the base register and both hold registers clear at the clock edge. After reset, `vm_count` and `fetch_addr` read 0, and a load with no other activity reloads 0.
- R2: An enabled step with no load adds 1 to the whole 12-bit counter, with normal carry between nibbles within the step (for example $0FF becomes $100).
- R3: `fetch_addr` always equals (`vm_count` + 1) >> 1, computed without losing the carry out of bit 11.
- R4: An enabled load sets the counter to the base value. The middle-boundary hold register (carry into bit 4) is added to bits 7..4, and the top-boundary hold register (carry into bit 8) is added to bits 11..8. Bits 3..0 take the base unchanged.
- R5: An enabled step sets the middle hold register exactly when the step wraps bits 3..0 to zero, and the top hold register exactly when it wraps bits 7..0 to zero. Otherwise it clears them. A load leaves both hold registers unchanged.
- R6: A held carry added during a load wraps within its nibble and does not ripple further. A base of $0F0 with the middle carry held reloads as $000.
- R7: When the last step of a line leaves bits 7..0 at zero, the next load yields base + $110 (each nibble wrapping).
- R8: With save and load asserted in the same enabled cycle, the base register takes the current counter value, and the load uses that same value as its base.
- R9: An enabled field clear sets the base register to 0. It overrides save, and a load in the same cycle uses 0 as its base.
- R10: With `phase_en` low, no strobe changes the counter, the base register or the hold registers.
- R11: An enabled cycle without save or field clear leaves the base register unchanged, as seen by the value a later load produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_en | input | 1 | Qualifies all strobes (active clock phase) |
| line_load | input | 1 | Reload counter from base at start of line |
| char_step | input | 1 | Advance counter after a character fetch |
| row_save | input | 1 | Copy counter into base on last line of a row |
| field_clr | input | 1 | Clear base register during vertical sync |
| vm_count | output | 12 | Current counter value |
| fetch_addr | output | 12 | Fetch address, (vm_count + 1) >> 1 |

## Verification
The checker assumes that `line_load` and `char_step` are never high in the same cycle. Its step and reload properties rely on that exclusion, so it flags any stimulus that breaks it. The bench issues each line as one load cycle followed by a run of steps, and never raises both strobes together, even in cycles where `phase_en` is low. Save and field clear appear only in load cycles or in disabled cycles, matching how row and field boundaries arrive in a real raster. A sweep over many per-line step counts then drives the counter through both stale-carry cases against an arithmetic model.

// File: rtl/vmc_pkg.sv
// Package: shared sizing and nibble arithmetic for the video matrix counter.
// Assumes nibble width of at least 1 bit; all math wraps at the nibble width.
package vmc_pkg;

    localparam int DEF_NIB_W = 4;
    localparam int DEF_NIBS  = 3;

endpackage

// File: rtl/vmc_nibble.sv
// One nibble of the offset counter. It reloads from its base slice, adding the
// held carry (wrapping inside the nibble), or steps by the ripple carry.
// Assumes load and step are never asserted in the same cycle.
module vmc_nibble #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] base_nib,
    input  logic         held_cin,
    input  logic         ripple_cin,
    output logic [W-1:0] q
);

    logic [W-1:0] held_ext;
    logic [W-1:0] ripple_ext;

    // Widen the single-bit carries to nibble width for wrapping adds.
    always_comb begin
        held_ext   = '0;
        ripple_ext = '0;
        held_ext[0]   = held_cin;
        ripple_ext[0] = ripple_cin;
    end

    // Nibble register: reload with held carry, or step with ripple carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en && load) begin
            q <= base_nib + held_ext;
        end else if (en && step) begin
            q <= q + ripple_ext;
        end
    end

endmodule

// File: rtl/vmc_carry_hold.sv
// Hold registers for the carries between nibbles. They capture the carry out
// of each lower group on an enabled step only; on any other cycle they keep
// their value, which a following reload then applies.
module vmc_carry_hold #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         step,
    input  logic [N-1:0] carry_d,
    output logic [N-1:0] carry_q
);

    // Update held carries only when a step is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= '0;
        end else if (en && step) begin
            carry_q <= carry_d;
        end
    end

endmodule

// File: rtl/vmc_base_reg.sv
// Row base register. Field clear wins over save; the next-state value is also
// exported so a reload in the same cycle sees the value being stored.
module vmc_base_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         save,
    input  logic         clr,
    input  logic [W-1:0] count,
    output logic [W-1:0] base_q,
    output logic [W-1:0] base_nxt
);

    // Select the value the base register takes this cycle.
    always_comb begin
        if (clr) begin
            base_nxt = '0;
        end else if (save) begin
            base_nxt = count;
        end else begin
            base_nxt = base_q;
        end
    end

    // Store the selected base value on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (en) begin
            base_q <= base_nxt;
        end
    end

endmodule

// File: rtl/vmc_top.sv
// Video matrix offset counter with held inter-nibble carries.
// Assumes: line_load and char_step are mutually exclusive; all strobes are
// qualified by phase_en; NIBS is at least 2.
module vmc_top #(
    parameter int NIB_W = vmc_pkg::DEF_NIB_W,
    parameter int NIBS  = vmc_pkg::DEF_NIBS,
    parameter int CNT_W = NIB_W * NIBS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_en,
    input  logic             line_load,
    input  logic             char_step,
    input  logic             row_save,
    input  logic             field_clr,
    output logic [CNT_W-1:0] vm_count,
    output logic [CNT_W-1:0] fetch_addr
);

    localparam int NB = NIBS - 1;

    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] base_nxt;
    logic [NIBS-1:0]  ripple;
    logic [NB-1:0]    held_q;
    logic [NIBS-1:0]  held_in;
    logic [CNT_W:0]   addr_sum;

    // Immediate ripple carry chain used while stepping.
    always_comb begin
        ripple[0] = 1'b1;
        for (int k = 1; k < NIBS; k++) begin
            ripple[k] = ripple[k-1] & (&vm_count[k*NIB_W-1 -: NIB_W]);
        end
    end

    // Carry into each nibble during reload: none into nibble 0, held above.
    always_comb begin
        held_in = {held_q, 1'b0};
    end

    vmc_base_reg #(.W(CNT_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (phase_en),
        .save     (row_save),
        .clr      (field_clr),
        .count    (vm_count),
        .base_q   (base_q),
        .base_nxt (base_nxt)
    );

    vmc_carry_hold #(.N(NB)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (phase_en),
        .step    (char_step),
        .carry_d (ripple[NIBS-1:1]),
        .carry_q (held_q)
    );

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        vmc_nibble #(.W(NIB_W)) u_nib (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (phase_en),
            .load       (line_load),
            .step       (char_step),
            .base_nib   (base_nxt[g*NIB_W +: NIB_W]),
            .held_cin   (held_in[g]),
            .ripple_cin (ripple[g]),
            .q          (vm_count[g*NIB_W +: NIB_W])
        );
    end

    // Fetch address: counter plus one, halved, keeping the top carry.
    always_comb begin
        addr_sum   = {1'b0, vm_count} + {{CNT_W{1'b0}}, 1'b1};
        fetch_addr = addr_sum[CNT_W:1];
    end

endmodule

// File: rtl/vmc_checker.sv
// Property checker for vmc_top, attached by bind. Assumes the exclusion of
// load and step and checks register behaviour across cycles.
module vmc_checker #(
    parameter int CNT_W = 12,
    parameter int NB    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase_en,
    input logic             line_load,
    input logic             char_step,
    input logic             row_save,
    input logic             field_clr,
    input logic [CNT_W-1:0] vm_count,
    input logic [CNT_W-1:0] base_q,
    input logic [NB-1:0]    held_q
);

    // Input assumption behind R4 and R2: never load and step together.
    p_load_step_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_load && char_step));

    p_step_adds_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && char_step && !line_load) |=> vm_count == $past(vm_count) + 1'b1);

    p_load_keeps_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && line_load) |=> $stable(held_q));

    p_save_copies_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && row_save && !field_clr) |=> base_q == $past(vm_count));

    p_field_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && field_clr) |=> base_q == '0);

    p_idle_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_en |=> ($stable(vm_count) && $stable(base_q) && $stable(held_q)));

    p_base_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && !row_save && !field_clr) |=> $stable(base_q));

endmodule

bind vmc_top vmc_checker #(.CNT_W(CNT_W), .NB(NIBS - 1)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_en  (phase_en),
    .line_load (line_load),
    .char_step (char_step),
    .row_save  (row_save),
    .field_clr (field_clr),
    .vm_count  (vm_count),
    .base_q    (base_q),
    .held_q    (held_q)
);

// File: tb/tb_vmc_top.sv
// Self-checking bench: directed corner cases plus a sweep of per-line step
// counts against an arithmetic model of the counter.
module tb_vmc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, ld = 1'b0, st = 1'b0, sv = 1'b0, fc = 1'b0;
    logic [11:0] vm_count, fetch_addr;

    int n_chk = 0;
    int n_fail = 0;

    logic [11:0] m_vm = '0, m_vb = '0;
    logic        m_c4 = 1'b0, m_c8 = 1'b0;

    always #4 clk = ~clk;

    vmc_top dut (
        .clk(clk), .rst_n(rst_n), .phase_en(en), .line_load(ld),
        .char_step(st), .row_save(sv), .field_clr(fc),
        .vm_count(vm_count), .fetch_addr(fetch_addr)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive strobes, advance the model, compare outputs.
    task automatic cyc(input logic l, input logic s, input logic v, input logic f, input logic e);
        logic [11:0] src, nvm;
        @(negedge clk);
        ld = l; st = s; sv = v; fc = f; en = e;
        @(posedge clk);
        #2;
        if (e) begin
            src = f ? 12'h000 : (v ? m_vm : m_vb);
            nvm = m_vm;
            if (l) begin
                nvm = {src[11:8] + {3'b000, m_c8}, src[7:4] + {3'b000, m_c4}, src[3:0]};
            end else if (s) begin
                nvm  = m_vm + 12'h001;
                m_c4 = (nvm[3:0] == 4'h0);
                m_c8 = (nvm[7:0] == 8'h00);
            end
            m_vb = src;
            m_vm = nvm;
        end
        check(l ? "R4" : (s ? "R2" : "R10"), vm_count, m_vm);
        check("R3", fetch_addr, 12'((13'(m_vm) + 13'd1) >> 1));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; ld = 1'b0; st = 1'b0; sv = 1'b0; fc = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        m_vm = '0; m_vb = '0; m_c4 = 1'b0; m_c8 = 1'b0;
        check("R1", vm_count, 12'h000);
        check("R1", fetch_addr, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int exp44 [10];
        exp44 = '{0, 0, 22, 22, 44, 44, 66, 74, 104, 96};

        do_reset();

        // R2/R3: ripple across nibbles within a line
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        steps(255);
        check("R2", vm_count, 12'h0FF);
        check("R3", fetch_addr, 12'h080);
        steps(1);
        check("R2", vm_count, 12'h100);

        // R7/R8: low byte zero, save with load gives +$110
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R7", vm_count, 12'h210);
        // R5/R11: load keeps carries, base unchanged without save
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R11", vm_count, 12'h210);
        // R5: a non-wrapping step clears held carries
        steps(1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R5", vm_count, 12'h100);

        // R10: disabled strobes change nothing
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R10", vm_count, 12'h100);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R10", vm_count, 12'h100);

        // R6: forced middle carry wraps within the nibble
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        steps(240);
        check("R6", vm_count, 12'h0F0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R6", vm_count, 12'h000);

        // R9: field clear overrides save, load uses 0
        steps(3);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R9", vm_count, 12'h000);
        steps(5);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R9", vm_count, 12'h000);

        // R4/R8: first-column addresses for 44 steps per line
        for (int row = 0; row < 5; row++) begin
            for (int ln = 0; ln < 8; ln++) begin
                cyc(1'b1, 1'b0, (ln == 0 && row != 0), (ln == 0 && row == 0), 1'b1);
                if (ln < 2) check("R4", fetch_addr, 12'(exp44[row*2+ln]));
                steps(44);
            end
        end

        // Sweep of per-line step counts against the model (R2 R4 R5 R7 R8)
        for (int inc = 4; inc <= 68; inc += 4) begin
            for (int row = 0; row < 4; row++) begin
                for (int ln = 0; ln < 8; ln++) begin
                    cyc(1'b1, 1'b0, (ln == 0 && row != 0), (ln == 0 && row == 0), 1'b1);
                    steps(inc);
                    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
                end
            end
        end

        // R1: reset mid-run clears counter, base and held carries
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        steps(256);
        do_reset();
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R1", vm_count, 12'h000);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule